// File: doc/BRIEF.md
# Timed Receive Stream Sequencer

This block decides which receive samples reach the downstream packetiser. Software writes commands through a small 32-bit register port; each command names a sample count, whether it starts at once or at a given time, and what happens when it ends. The command flags and count sit in one word and the start time is given as whole seconds and a tick count. Writing the tick value queues the command, together with the word and the seconds value written before it, in a small FIFO. The block compares the start time with a free-running 64-bit time input, then forwards exactly the requested number of samples one cycle after it accepts each of them.

A chained command runs straight into the next queued command with no idle cycle. A reloaded command runs again with the same count, and with a count of one that gives continuous streaming until a queued stop replaces it. Packet boundaries are marked every N forwarded samples and at the end of each command. Three errors are reported: a late start, a chain with nothing queued behind it, and a sample that arrives while downstream cannot take it.

Top module: `rx_stream_gate`

## Requirements
- R1: After reset, out_valid_o, out_eop_o, busy_o, overflow_o, late_o and chain_err_o are all low, and the samples-per-packet value is 16.
- R2: Register offsets: 0 holds the command word, 1 the start seconds, 2 the start ticks, 3 is clear and 7 is samples per packet. Only a write to offset 2 queues a command. In the command word, bit 31 means start now and ignore the time, bit 30 is chain, bit 29 is reload and bits 28:0 are the count.
- R3: An immediate command with count N forwards exactly the next N accepted samples with their data unchanged. Each out_valid_o appears one cycle after the sample was accepted.
- R4: A timed command holds busy_o high and forwards nothing until {seconds, ticks} from the time inputs is equal to or greater than its start time. It accepts its first sample in the cycle after that.
- R5: A timed command whose start time is already earlier than the time input when it reaches the head of the queue is dropped. late_o pulses for one cycle and no sample is forwarded.
- R6: out_eop_o marks every Nth forwarded sample, where N is the samples-per-packet value. A value of 0 turns this marking off.
- R7: out_eop_o also marks the final sample of every command, except a final sample after which the same command reloads.
- R8: A chained command whose successor is already queued hands over on the cycle after its final sample, so no sample is lost in between.
- R9: A chained command that ends with an empty queue stops the stream and sets chain_err_o. chain_err_o clears when the next command starts or on clear.
- R10: A reloaded command restarts with the same count and no time check. A command queued behind it replaces it at the end of the current pass. A command with count 0 is a stop: it is consumed and streams nothing.
- R11: A sample that arrives while dn_ready_i is low during streaming is dropped and sets overflow_o. Nothing more is forwarded until a queued command starts, which clears overflow_o.
- R12: A write of any value to the clear offset empties the queue, ends any stream or wait, and clears overflow_o and chain_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| time_secs_i | input | 32 | Current time, whole seconds |
| time_ticks_i | input | 32 | Current time, ticks within the second |
| smp_valid_i | input | 1 | Input sample present |
| smp_data_i | input | DATA_W | Input sample |
| dn_ready_i | input | 1 | Downstream can accept a sample |
| out_valid_o | output | 1 | Forwarded sample valid |
| out_data_o | output | DATA_W | Forwarded sample |
| out_eop_o | output | 1 | Last sample of a packet |
| busy_o | output | 1 | Waiting for a start time or streaming |
| overflow_o | output | 1 | Stream halted by a sample downstream refused |
| late_o | output | 1 | One-cycle pulse: late command dropped |
| chain_err_o | output | 1 | Chain ended with an empty queue |

## Verification
The assertions check on every cycle that each forwarded sample matches an accepted sample in the cycle before, and that overflow rises only after a refused sample and never while samples are being forwarded. They also check that late and chain-error events leave the block idle, that every packet end comes with a valid sample, and that a clear write always ends in an idle, error-free state. Exact sample counts, packet-end positions, the cycle a timed start first forwards a sample, a gapless chain handover and the queued stop that replaces a continuous stream depend on whole command sequences, so only the bench scenarios show them.

// File: rtl/rx_gate_pkg.sv
package rx_gate_pkg;
  localparam int CNT_W  = 29;
  localparam int TIME_W = 64;

  // register offsets
  localparam int OFS_CMD   = 0;
  localparam int OFS_SECS  = 1;
  localparam int OFS_TICKS = 2;
  localparam int OFS_CLEAR = 3;
  localparam int OFS_SPP   = 7;

  // command word flag positions
  localparam int BIT_NOW    = 31;
  localparam int BIT_CHAIN  = 30;
  localparam int BIT_RELOAD = 29;

  typedef struct packed {
    logic             now;
    logic             chain;
    logic             reload;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      secs;
    logic [31:0]      ticks;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_HALT
  } st_e;
endpackage

// File: rtl/rx_gate_regs.sv
module rx_gate_regs
  import rx_gate_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int SPP_W   = 16,
  parameter int SPP_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              push_o,
  output cmd_t              push_cmd_o,
  output logic              clear_o,
  output logic [SPP_W-1:0]  spp_o
);
  logic [31:0]      cmd_word_q;
  logic [31:0]      secs_q;
  logic [SPP_W-1:0] spp_q;

  logic hit_cmd, hit_secs, hit_ticks, hit_clear, hit_spp;

  assign hit_cmd   = we_i && (addr_i == ADDR_W'(OFS_CMD));
  assign hit_secs  = we_i && (addr_i == ADDR_W'(OFS_SECS));
  assign hit_ticks = we_i && (addr_i == ADDR_W'(OFS_TICKS));
  assign hit_clear = we_i && (addr_i == ADDR_W'(OFS_CLEAR));
  assign hit_spp   = we_i && (addr_i == ADDR_W'(OFS_SPP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_word_q <= '0;
      secs_q     <= '0;
      spp_q      <= SPP_W'(SPP_RST);
    end else begin
      if (hit_cmd)  cmd_word_q <= wdata_i;
      if (hit_secs) secs_q     <= wdata_i;
      if (hit_spp)  spp_q      <= wdata_i[SPP_W-1:0];
    end
  end

  // tick write carries the whole staged command into the queue
  always_comb begin
    push_cmd_o.now    = cmd_word_q[BIT_NOW];
    push_cmd_o.chain  = cmd_word_q[BIT_CHAIN];
    push_cmd_o.reload = cmd_word_q[BIT_RELOAD];
    push_cmd_o.cnt    = cmd_word_q[CNT_W-1:0];
    push_cmd_o.secs   = secs_q;
    push_cmd_o.ticks  = wdata_i;
  end

  assign push_o  = hit_ticks;
  assign clear_o = hit_clear;
  assign spp_o   = spp_q;
endmodule

// File: rtl/rx_gate_fifo.sv
module rx_gate_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         valid_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign valid_o = (cnt_q != '0);
endmodule

// File: rtl/rx_gate_ctrl.sv
module rx_gate_ctrl
  import rx_gate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SPP_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  cmd_t              head_i,
  input  logic              head_valid_i,
  output logic              pop_o,
  input  logic [TIME_W-1:0] now_i,
  input  logic [SPP_W-1:0]  spp_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              dn_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_eop_o,
  output logic              busy_o,
  output logic              overflow_o,
  output logic              late_o,
  output logic              chain_err_o
);
  st_e               st_q, st_d;
  logic              chain_q, chain_d, reload_q, reload_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, left_q, left_d;
  logic [TIME_W-1:0] start_q, start_d;
  logic [SPP_W-1:0]  pkt_q, pkt_d;
  logic              ovf_q, ovf_d, cerr_q, cerr_d, late_q, late_d;
  logic              vld_q, eop_q, eop_d;
  logic [DATA_W-1:0] data_q;

  logic              take, overrun, last, pkt_end, launch;
  logic              head_late, head_stop;
  logic [TIME_W-1:0] head_start;

  assign head_start = {head_i.secs, head_i.ticks};
  assign head_stop  = (head_i.cnt == '0);
  assign head_late  = !head_i.now && (head_start < now_i);

  assign take    = (st_q == ST_RUN) && smp_valid_i && dn_ready_i;
  assign overrun = (st_q == ST_RUN) && smp_valid_i && !dn_ready_i;
  assign last    = take && (left_q == CNT_W'(1));
  assign pkt_end = (spp_i != '0) && (pkt_q == spp_i - 1'b1);

  always_comb begin
    st_d     = st_q;
    chain_d  = chain_q;
    reload_d = reload_q;
    cnt_d    = cnt_q;
    start_d  = start_q;
    left_d   = left_q;
    pkt_d    = pkt_q;
    ovf_d    = ovf_q;
    cerr_d   = cerr_q;
    late_d   = 1'b0;
    eop_d    = 1'b0;
    launch   = 1'b0;

    unique case (st_q)
      ST_IDLE: launch = head_valid_i;
      ST_WAIT: if (start_q <= now_i) st_d = ST_RUN;
      ST_RUN: begin
        if (overrun) begin
          ovf_d = 1'b1;
          st_d  = ST_HALT;
        end else if (take) begin
          left_d = left_q - 1'b1;
          if (last) begin
            if ((chain_q || reload_q) && head_valid_i) begin
              launch = 1'b1;
            end else if (reload_q) begin
              left_d = cnt_q;
            end else begin
              st_d   = ST_IDLE;
              cerr_d = chain_q;
            end
          end
          // a pass that reloads is not a burst end
          eop_d = pkt_end || (last && !(reload_q && !head_valid_i));
          pkt_d = eop_d ? '0 : pkt_q + 1'b1;
        end
      end
      ST_HALT: launch = head_valid_i;
      default: st_d = ST_IDLE;
    endcase

    if (launch) begin
      chain_d  = head_i.chain;
      reload_d = head_i.reload;
      cnt_d    = head_i.cnt;
      left_d   = head_i.cnt;
      start_d  = head_start;
      ovf_d    = 1'b0;
      cerr_d   = 1'b0;
      late_d   = head_late && !head_stop;
      if (st_q != ST_RUN) pkt_d = '0;
      if (head_stop || head_late) st_d = ST_IDLE;
      else if (head_i.now)        st_d = ST_RUN;
      else                        st_d = ST_WAIT;
    end

    if (clear_i) begin
      st_d   = ST_IDLE;
      pkt_d  = '0;
      ovf_d  = 1'b0;
      cerr_d = 1'b0;
      late_d = 1'b0;
      eop_d  = 1'b0;
    end
  end

  assign pop_o = launch && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      chain_q  <= 1'b0;
      reload_q <= 1'b0;
      cnt_q    <= '0;
      left_q   <= '0;
      start_q  <= '0;
      pkt_q    <= '0;
      ovf_q    <= 1'b0;
      cerr_q   <= 1'b0;
      late_q   <= 1'b0;
      vld_q    <= 1'b0;
      eop_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      st_q     <= st_d;
      chain_q  <= chain_d;
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      left_q   <= left_d;
      start_q  <= start_d;
      pkt_q    <= pkt_d;
      ovf_q    <= ovf_d;
      cerr_q   <= cerr_d;
      late_q   <= late_d;
      vld_q    <= take && !clear_i;
      eop_q    <= eop_d;
      if (take) data_q <= smp_data_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = data_q;
  assign out_eop_o   = eop_q;
  assign busy_o      = (st_q == ST_WAIT) || (st_q == ST_RUN);
  assign overflow_o  = ovf_q;
  assign late_o      = late_q;
  assign chain_err_o = cerr_q;
endmodule

// File: rtl/rx_stream_gate.sv
module rx_stream_gate
  import rx_gate_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int SPP_W   = 16,
  parameter int SPP_RST = 16,
  parameter int QDEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [31:0]       time_secs_i,
  input  logic [31:0]       time_ticks_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              dn_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_eop_o,
  output logic              busy_o,
  output logic              overflow_o,
  output logic              late_o,
  output logic              chain_err_o
);
  localparam int CMD_W = $bits(cmd_t);

  logic             push, clear, pop, head_valid;
  cmd_t             push_cmd, head;
  logic [CMD_W-1:0] head_raw;
  logic [SPP_W-1:0] spp;

  rx_gate_regs #(
    .ADDR_W (ADDR_W),
    .SPP_W  (SPP_W),
    .SPP_RST(SPP_RST)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .push_o    (push),
    .push_cmd_o(push_cmd),
    .clear_o   (clear),
    .spp_o     (spp)
  );

  rx_gate_fifo #(
    .W    (CMD_W),
    .DEPTH(QDEPTH)
  ) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(clear),
    .push_i (push),
    .din_i  (push_cmd),
    .pop_i  (pop),
    .dout_o (head_raw),
    .valid_o(head_valid)
  );

  assign head = cmd_t'(head_raw);

  rx_gate_ctrl #(
    .DATA_W(DATA_W),
    .SPP_W (SPP_W)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .head_i      (head),
    .head_valid_i(head_valid),
    .pop_o       (pop),
    .now_i       ({time_secs_i, time_ticks_i}),
    .spp_i       (spp),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .dn_ready_i  (dn_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_eop_o   (out_eop_o),
    .busy_o      (busy_o),
    .overflow_o  (overflow_o),
    .late_o      (late_o),
    .chain_err_o (chain_err_o)
  );
endmodule

// File: rtl/rx_gate_chk.sv
module rx_gate_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              smp_valid_i,
  input logic              dn_ready_i,
  input logic              out_valid_o,
  input logic              out_eop_o,
  input logic              busy_o,
  input logic              overflow_o,
  input logic              late_o,
  input logic              chain_err_o
);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(3);

  // R3
  out_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(smp_valid_i && dn_ready_i));

  // R11
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(smp_valid_i && !dn_ready_i));

  // R11
  no_fwd_in_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !overflow_o);

  // R5
  late_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o |-> !busy_o);

  // R9
  chain_err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chain_err_o) |-> !busy_o);

  // R6
  eop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |-> out_valid_o);

  // R12
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_we_i && (reg_addr_i == CLR_ADDR)) |-> (!busy_o && !overflow_o && !chain_err_o));
endmodule

bind rx_stream_gate rx_gate_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .smp_valid_i(smp_valid_i),
  .dn_ready_i (dn_ready_i),
  .out_valid_o(out_valid_o),
  .out_eop_o  (out_eop_o),
  .busy_o     (busy_o),
  .overflow_o (overflow_o),
  .late_o     (late_o),
  .chain_err_o(chain_err_o)
);

// File: tb/test_rx_stream_gate.sv
`timescale 1ns/1ps
module test_rx_stream_gate;
  localparam logic [31:0] NOW = 32'h8000_0000;
  localparam logic [31:0] CHN = 32'h4000_0000;
  localparam logic [31:0] RLD = 32'h2000_0000;

  typedef struct packed {
    logic [31:0] cmd;
    logic [31:0] spp;
    logic [31:0] nsmp;
    logic [31:0] nout;
    logic [31:0] neop;
  } vec_t;

  // R3 / R6 / R7: immediate bursts with assorted packet sizes
  localparam vec_t VECS [5] = '{
    '{NOW | 32'd5,  32'd16, 32'd10, 32'd5,  32'd1},
    '{NOW | 32'd10, 32'd4,  32'd20, 32'd10, 32'd3},
    '{NOW | 32'd8,  32'd4,  32'd14, 32'd8,  32'd2},
    '{NOW | 32'd1,  32'd4,  32'd5,  32'd1,  32'd1},
    '{NOW | 32'd3,  32'd0,  32'd8,  32'd3,  32'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] tb_secs = 32'd7;
  logic [31:0] tb_ticks;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        dn_ready = 1'b1;
  logic        out_valid, out_eop, busy, overflow, late, chain_err;
  logic [31:0] out_data;

  int tests = 0;
  int fails = 0;
  int mon_out = 0, mon_eop = 0, mon_late = 0;
  logic [31:0] mon_last = '0;
  logic [31:0] dctr = '0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_ticks <= 32'd100;
    else        tb_ticks <= tb_ticks + 1;

  rx_stream_gate i_rx_stream_gate (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (reg_we),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .time_secs_i (tb_secs),
    .time_ticks_i(tb_ticks),
    .smp_valid_i (smp_valid),
    .smp_data_i  (smp_data),
    .dn_ready_i  (dn_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .out_eop_o   (out_eop),
    .busy_o      (busy),
    .overflow_o  (overflow),
    .late_o      (late),
    .chain_err_o (chain_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        mon_out  = mon_out + 1;
        mon_last = out_data;
        if (out_eop) mon_eop = mon_eop + 1;
      end
      if (late) mon_late = mon_late + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] cmd, input logic [31:0] s, input logic [31:0] t);
    wr(4'd0, cmd);
    wr(4'd1, s);
    wr(4'd2, t);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input int n, input logic rdy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_data = dctr; dn_ready = rdy;
      dctr = dctr + 1;
    end
    @(negedge clk);
    smp_valid = 1'b0; dn_ready = 1'b1;
  endtask

  int b_out, b_eop, b_late;
  task automatic snap();
    b_out = mon_out; b_eop = mon_eop; b_late = mon_late;
  endtask

  initial begin
    logic [31:0] d0, start;
    logic [31:0] first_tick;
    logic        seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 errors", {overflow, late, chain_err}, 0);

    // R1 default packet size: 20 samples give eops at 16 and 20
    snap(); issue(NOW | 32'd20, 0, 0); idle(2); send(24, 1'b1); idle(4);
    chk("R1 default spp eops", mon_eop - b_eop, 2);

    // table of immediate bursts
    for (int v = 0; v < 5; v++) begin
      wr(4'd7, VECS[v].spp);
      snap();
      issue(VECS[v].cmd, 0, 0);
      idle(2);
      d0 = dctr;
      send(int'(VECS[v].nsmp), 1'b1);
      idle(4);
      chk("R3 sample count", mon_out - b_out, VECS[v].nout);
      chk("R3 data passthrough", mon_last, d0 + VECS[v].nout - 1);
      chk("R6/R7 eop count", mon_eop - b_eop, VECS[v].neop);
    end

    // R2 only the tick write arms the command
    wr(4'd7, 32'd16);
    wr(4'd0, NOW | 32'd3); wr(4'd1, 0); idle(3);
    chk("R2 not armed before tick write", busy, 0);
    snap(); wr(4'd2, 0); idle(2);
    chk("R2 armed by tick write", busy, 1);
    send(5, 1'b1); idle(4);
    chk("R2 count field", mon_out - b_out, 3);

    // R4 timed start
    snap();
    wr(4'd0, 32'd4); wr(4'd1, 32'd7);
    start = tb_ticks + 40;
    wr(4'd2, start);
    idle(3);
    chk("R4 waiting busy", busy, 1);
    chk("R4 nothing before time", mon_out - b_out, 0);
    seen = 1'b0; first_tick = '0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (out_valid && !seen) begin seen = 1'b1; first_tick = tb_ticks; end
      smp_valid = 1'b1; smp_data = dctr; dctr = dctr + 1;
    end
    @(negedge clk); smp_valid = 1'b0;
    idle(4);
    chk("R4 first output tick", first_tick, start + 2);
    chk("R4 timed count", mon_out - b_out, 4);

    // R5 late commands: same second earlier tick, and earlier second
    snap(); issue(32'd4, 32'd7, 32'd5); idle(3); send(8, 1'b1); idle(3);
    chk("R5 late pulse", mon_late - b_late, 1);
    chk("R5 late no samples", mon_out - b_out, 0);
    snap(); issue(32'd4, 32'd6, 32'hFFFF_FFF0); idle(3); send(8, 1'b1); idle(3);
    chk("R5 late by seconds", mon_late - b_late, 1);
    chk("R5 busy after late", busy, 0);

    // R8 chain hands over without a gap
    snap();
    issue(NOW | CHN | 32'd3, 0, 0);
    issue(NOW | 32'd2, 0, 0);
    idle(2); d0 = dctr; send(10, 1'b1); idle(4);
    chk("R8 chained count", mon_out - b_out, 5);
    chk("R8 contiguous data", mon_last, d0 + 4);
    chk("R7 eop per command", mon_eop - b_eop, 2);
    chk("R8 no chain error", chain_err, 0);

    // R9 chain into empty queue
    snap(); issue(NOW | CHN | 32'd3, 0, 0); idle(2); send(6, 1'b1); idle(3);
    chk("R9 chain count", mon_out - b_out, 3);
    chk("R9 chain_err set", chain_err, 1);
    chk("R9 stopped", busy, 0);

    // R10 continuous stream then queued stop
    wr(4'd7, 32'd4);
    snap(); issue(NOW | CHN | RLD | 32'd1, 0, 0); idle(2);
    chk("R9 chain_err cleared by new command", chain_err, 0);
    send(6, 1'b1); idle(3);
    chk("R10 reload count", mon_out - b_out, 6);
    chk("R10 eop only per packet", mon_eop - b_eop, 1);
    issue(32'd0, 0, 0); idle(2);
    chk("R10 still streaming", busy, 1);
    snap(); send(5, 1'b1); idle(3);
    chk("R10 one sample after stop", mon_out - b_out, 1);
    chk("R10 eop at stream end", mon_eop - b_eop, 1);
    chk("R10 stopped", busy, 0);

    // R11 overflow
    snap(); issue(NOW | CHN | RLD | 32'd1, 0, 0); idle(2);
    send(3, 1'b1); send(1, 1'b0); idle(2);
    chk("R11 overflow set", overflow, 1);
    chk("R11 pre-overflow count", mon_out - b_out, 3);
    snap(); send(4, 1'b1); idle(3);
    chk("R11 halted", mon_out - b_out, 0);
    issue(NOW | 32'd2, 0, 0); idle(2);
    chk("R11 overflow cleared", overflow, 0);
    send(4, 1'b1); idle(3);
    chk("R11 resumed count", mon_out - b_out, 2);

    // R12 clear ends a stream
    snap(); issue(NOW | 32'd100, 0, 0); idle(2); send(3, 1'b1);
    wr(4'd3, 32'd0); idle(1);
    chk("R12 idle after clear", busy, 0);
    send(5, 1'b1); idle(3);
    chk("R12 no samples after clear", mon_out - b_out, 3);

    // R12 clear ends a wait and flushes the queue
    issue(32'd4, 32'd8, 32'd0);
    issue(NOW | 32'd2, 0, 0); idle(2);
    chk("R12 waiting before clear", busy, 1);
    wr(4'd3, 32'd1); idle(2);
    snap(); send(6, 1'b1); idle(3);
    chk("R12 queue flushed", mon_out - b_out, 0);
    chk("R12 busy low", busy, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule